// File: doc/BRIEF.md
# Pseudo-Associative Cache Lookup Controller

This block sits in front of a direct-mapped line store and gives it a second chance on a miss. A CPU request is first looked up at its normal index. When that location does not hold the requested line, the controller looks at a partner location, namely the same index with its top bit inverted. A hit there answers the request one cycle later than a normal hit. The controller then exchanges the two lines, so that the next access to the same address hits on the first look.

When both locations miss, the controller issues a single read to the next memory level and waits for the line. It installs that line at the normal index and moves the line previously held there into the partner location. The line that sat in the partner location is dropped. Every response carries a hit-type code, so a caller can tell a direct hit, a partner hit and a refill apart.

The store holds one data word per line. Requests are read-only and are taken one at a time. The request port is ready only while the controller is idle.

Top module: `pseudo_assoc_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and every line is invalid, so the first access to any address is a refill.
- R2: A request accepted at clock edge E that hits at its normal index (address bits [IDX_W-1:0]) shows `rsp_valid`=1 with `rsp_kind`=2'b01 and the stored word in the cycle after edge E+1, and `req_ready` is back to 1 in that same cycle.
- R3: On a miss at the normal index, the partner index (the normal index with bit IDX_W-1 inverted) is looked up. A hit there gives `rsp_valid` with `rsp_kind`=2'b10 in the cycle after edge E+2.
- R4: After a partner hit, the two lines are exchanged. The next access to the same address is a direct hit, and the line that was at the normal index now answers as a partner hit.
- R5: After a partner hit, `req_ready` stays 0 for two more cycles for the exchange, so it is 0 for four cycles after acceptance.
- R6: When both lookups miss, `mem_req_valid` is 1 for exactly one cycle, in the cycle after edge E+2, with `mem_req_addr` equal to the request address.
- R7: The refill response (`rsp_kind`=2'b11, data = `mem_rsp_data`) appears in the cycle after the clock edge that samples `mem_rsp_valid`=1. The new line goes to the normal index. A valid line previously at the normal index moves to the partner index, and the old partner line is dropped.
- R8: A stored tag holds the upper address bits together with index bit IDX_W-1. Two addresses with equal upper bits whose indices differ only in that bit never hit on each other's line.
- R9: `mem_rsp_valid` has no effect unless a refill is outstanding. It produces no response and does not change the stored lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | CPU read request present |
| req_addr | input | ADDR_W | CPU word address |
| req_ready | output | 1 | Controller idle, request taken when both this and `req_valid` are 1 |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Line word returned to the CPU |
| rsp_kind | output | 2 | 01 direct hit, 10 partner hit, 11 refill |
| mem_req_valid | output | 1 | One-cycle read request to the next level |
| mem_req_addr | output | ADDR_W | Address of the refill read |
| mem_rsp_valid | input | 1 | Refill data present |
| mem_rsp_data | input | DATA_W | Refill line word |

## Verification
The bench builds the block with ADDR_W=12, IDX_W=4 and DATA_W=16, and runs the next-level memory model with a fixed three-cycle latency. With only sixteen lines, a handful of addresses share one pair of partner locations. Short directed sequences can therefore drive a line through install, move on refill, partner hit, exchange and eviction. Each step is then checked for its kind, its data, its response latency and how long the port stays busy.

// File: rtl/pac_pkg.sv
package pac_pkg;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'b00,
    KIND_FIRST  = 2'b01,
    KIND_SECOND = 2'b10,
    KIND_MISS   = 2'b11
  } hit_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PROBE1 = 3'd1,
    ST_PROBE2 = 3'd2,
    ST_SWAP_A = 3'd3,
    ST_SWAP_B = 3'd4,
    ST_MREQ   = 3'd5,
    ST_MWAIT  = 3'd6
  } ctrl_state_e;

endpackage

// File: rtl/pac_line_store.sv
module pac_line_store #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic              rd0_vld,
  output logic [TAG_W-1:0]  rd0_tag,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic              rd1_vld,
  output logic [TAG_W-1:0]  rd1_tag,
  output logic [DATA_W-1:0] rd1_data,
  input  logic              wa_en,
  input  logic [IDX_W-1:0]  wa_idx,
  input  logic              wa_vld,
  input  logic [TAG_W-1:0]  wa_tag,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic              wb_vld,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data
);

  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              hit_a, hit_b, upd;
    logic              vld_d;
    logic [TAG_W-1:0]  tag_d;
    logic [DATA_W-1:0] data_d;

    always_comb begin
      hit_a  = wa_en && (wa_idx == IDX_W'(g));
      hit_b  = wb_en && (wb_idx == IDX_W'(g));
      upd    = hit_a || hit_b;
      vld_d  = hit_a ? wa_vld  : wb_vld;
      tag_d  = hit_a ? wa_tag  : wb_tag;
      data_d = hit_a ? wa_data : wb_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
      end else if (upd) begin
        vld_q[g] <= vld_d;
      end
    end

    always_ff @(posedge clk) begin
      if (upd) begin
        tag_q[g]  <= tag_d;
        data_q[g] <= data_d;
      end
    end
  end

  always_comb begin
    rd0_vld  = vld_q[rd0_idx];
    rd0_tag  = tag_q[rd0_idx];
    rd0_data = data_q[rd0_idx];
    rd1_vld  = vld_q[rd1_idx];
    rd1_tag  = tag_q[rd1_idx];
    rd1_data = data_q[rd1_idx];
  end

  AST_WRITE_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wb_en) |-> (wa_idx != wb_idx)); // R7

endmodule

// File: rtl/pac_probe.sv
module pac_probe #(
  parameter int TAG_W = 9
) (
  input  logic             ent_vld,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [TAG_W-1:0] want_tag,
  output logic             hit
);

  always_comb begin
    hit = ent_vld && (ent_tag == want_tag);
  end

endmodule

// File: rtl/pac_ctrl_fsm.sv
module pac_ctrl_fsm
  import pac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_fire,
  input  logic        hit_home,
  input  logic        hit_alt,
  input  logic        mem_rsp_valid,
  output ctrl_state_e state
);

  ctrl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_fire)      state_d = ST_PROBE1;
      ST_PROBE1: state_d = hit_home ? ST_IDLE : ST_PROBE2;
      ST_PROBE2: state_d = hit_alt  ? ST_SWAP_A : ST_MREQ;
      ST_SWAP_A: state_d = ST_SWAP_B;
      ST_SWAP_B: state_d = ST_IDLE;
      ST_MREQ:   state_d = ST_MWAIT;
      ST_MWAIT:  if (mem_rsp_valid) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  AST_SWAP_TAKES_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SWAP_A) |=> (state_q == ST_SWAP_B)); // R5

endmodule

// File: rtl/pseudo_assoc_ctrl.sv
module pseudo_assoc_ctrl
  import pac_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_kind,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  localparam int UP_W  = ADDR_W - IDX_W;
  localparam int TAG_W = UP_W + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  ctrl_state_e state;
  logic        req_fire;

  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  home_idx, alt_idx;
  logic [TAG_W-1:0]  want_tag;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
    end else if (req_fire) begin
      addr_q <= req_addr;
    end
  end

  always_comb begin
    home_idx = addr_q[IDX_W-1:0];
    alt_idx  = {~addr_q[IDX_W-1], addr_q[IDX_W-2:0]};
    want_tag = {addr_q[ADDR_W-1:IDX_W], addr_q[IDX_W-1]};
  end

  // store ports
  logic              h_vld, a_vld;
  logic [TAG_W-1:0]  h_tag, a_tag;
  logic [DATA_W-1:0] h_data, a_data;
  logic              wa_en, wa_vld, wb_en, wb_vld;
  logic [TAG_W-1:0]  wa_tag, wb_tag;
  logic [DATA_W-1:0] wa_data, wb_data;

  pac_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd0_idx  (home_idx),
    .rd0_vld  (h_vld),
    .rd0_tag  (h_tag),
    .rd0_data (h_data),
    .rd1_idx  (alt_idx),
    .rd1_vld  (a_vld),
    .rd1_tag  (a_tag),
    .rd1_data (a_data),
    .wa_en    (wa_en),
    .wa_idx   (home_idx),
    .wa_vld   (wa_vld),
    .wa_tag   (wa_tag),
    .wa_data  (wa_data),
    .wb_en    (wb_en),
    .wb_idx   (alt_idx),
    .wb_vld   (wb_vld),
    .wb_tag   (wb_tag),
    .wb_data  (wb_data)
  );

  // one comparator per probe location
  logic [1:0]             probe_hit;
  logic [1:0]             probe_vld;
  logic [1:0][TAG_W-1:0]  probe_tag;

  assign probe_vld = {a_vld, h_vld};
  assign probe_tag = {a_tag, h_tag};

  for (genvar p = 0; p < 2; p++) begin : g_probe
    pac_probe #(.TAG_W(TAG_W)) u_probe (
      .ent_vld  (probe_vld[p]),
      .ent_tag  (probe_tag[p]),
      .want_tag (want_tag),
      .hit      (probe_hit[p])
    );
  end

  logic hit_home, hit_alt;
  assign hit_home = probe_hit[0];
  assign hit_alt  = probe_hit[1];

  pac_ctrl_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .req_fire      (req_fire),
    .hit_home      (hit_home),
    .hit_alt       (hit_alt),
    .mem_rsp_valid (mem_rsp_valid),
    .state         (state)
  );

  assign req_ready = (state == ST_IDLE) && rst_sync_n;
  assign req_fire  = req_valid && req_ready;

  // copies of both lines taken at the end of the first probe
  logic              hold_en;
  logic              hh_vld_q, ha_vld_q;
  logic [TAG_W-1:0]  hh_tag_q, ha_tag_q;
  logic [DATA_W-1:0] hh_data_q, ha_data_q;

  assign hold_en = (state == ST_PROBE1);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hh_vld_q <= 1'b0;
      ha_vld_q <= 1'b0;
    end else if (hold_en) begin
      hh_vld_q <= h_vld;
      ha_vld_q <= a_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_en) begin
      hh_tag_q  <= h_tag;
      hh_data_q <= h_data;
      ha_tag_q  <= a_tag;
      ha_data_q <= a_data;
    end
  end

  // write control: port A always targets the home index, port B the partner
  logic refill_done;
  assign refill_done = (state == ST_MWAIT) && mem_rsp_valid;

  always_comb begin
    wa_en   = 1'b0;
    wa_vld  = 1'b0;
    wa_tag  = want_tag;
    wa_data = mem_rsp_data;
    wb_en   = 1'b0;
    wb_vld  = hh_vld_q;
    wb_tag  = hh_tag_q;
    wb_data = hh_data_q;
    if (state == ST_SWAP_A) begin
      wa_en   = 1'b1;
      wa_vld  = ha_vld_q;
      wa_tag  = ha_tag_q;
      wa_data = ha_data_q;
    end else if (refill_done) begin
      wa_en   = 1'b1;
      wa_vld  = 1'b1;
    end
    if (state == ST_SWAP_B) begin
      wb_en = 1'b1;
    end else if (refill_done && hh_vld_q) begin
      wb_en = 1'b1;
    end
  end

  // response register
  logic              rsp_v_d, rsp_v_q;
  hit_kind_e         rsp_k_d, rsp_k_q;
  logic [DATA_W-1:0] rsp_dat_d, rsp_dat_q;

  always_comb begin
    rsp_v_d   = 1'b0;
    rsp_k_d   = KIND_NONE;
    rsp_dat_d = mem_rsp_data;
    if ((state == ST_PROBE1) && hit_home) begin
      rsp_v_d   = 1'b1;
      rsp_k_d   = KIND_FIRST;
      rsp_dat_d = h_data;
    end else if ((state == ST_PROBE2) && hit_alt) begin
      rsp_v_d   = 1'b1;
      rsp_k_d   = KIND_SECOND;
      rsp_dat_d = a_data;
    end else if (refill_done) begin
      rsp_v_d   = 1'b1;
      rsp_k_d   = KIND_MISS;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_v_q <= 1'b0;
      rsp_k_q <= KIND_NONE;
    end else begin
      rsp_v_q <= rsp_v_d;
      if (rsp_v_d) begin
        rsp_k_q <= rsp_k_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_v_d) begin
      rsp_dat_q <= rsp_dat_d;
    end
  end

  assign rsp_valid     = rsp_v_q;
  assign rsp_kind      = rsp_k_q;
  assign rsp_data      = rsp_dat_q;
  assign mem_req_valid = (state == ST_MREQ);
  assign mem_req_addr  = addr_q;

  AST_FIRST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state == ST_PROBE1) && hit_home) |=> (rsp_valid && (rsp_kind == KIND_FIRST) && req_ready)); // R2
  AST_SECOND_HIT_KIND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state == ST_PROBE2) && hit_alt) |=> (rsp_valid && (rsp_kind == KIND_SECOND))); // R3
  AST_SWAP_MAKES_HOME_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_SWAP_B) |=> hit_home); // R4
  AST_SECOND_HIT_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && (rsp_kind == KIND_SECOND)) |-> !req_ready); // R5
  AST_MEM_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req_valid |=> !mem_req_valid); // R6
  AST_REFILL_INSTALLS_HOME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    refill_done |=> (hit_home && rsp_valid && (rsp_kind == KIND_MISS))); // R7
  AST_IDLE_MEMRSP_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state == ST_IDLE) && mem_rsp_valid) |=> !rsp_valid); // R9
  AST_NO_DOUBLE_HIT_SAME_TAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_PROBE1) |-> !(hit_home && hit_alt)); // R8

endmodule

// File: tb/pseudo_assoc_ctrl_tb_top.sv
module pseudo_assoc_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int IDX_W      = 4;
  localparam int DATA_W     = 16;
  localparam int MEM_LAT    = 3;
  localparam int LAT_FIRST  = 1;
  localparam int LAT_SECOND = 2;
  localparam int LAT_MISS   = 3 + MEM_LAT;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_ready;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic [1:0]        rsp_kind;
  logic              mem_req_valid;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid;
  logic [DATA_W-1:0] mem_rsp_data;

  pseudo_assoc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_data      (rsp_data),
    .rsp_kind      (rsp_kind),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [1:0]        kind;
    int                acc;
    string             req;
  } exp_t;

  exp_t exp_q[$];
  logic [ADDR_W-1:0] cur_addr;

  function automatic logic [DATA_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return {a, 4'h0} ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: pushes the expectation, then presents the request
  task automatic issue(input logic [ADDR_W-1:0] a, input logic [1:0] kind,
                       input string req);
    exp_t e;
    int   busy;
    int   exp_busy;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    cur_addr  = a;
    e.addr = a; e.kind = kind; e.acc = cyc; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin
      busy++;
      @(negedge clk);
    end
    exp_busy = (kind == 2'b01) ? LAT_FIRST : (kind == 2'b10) ? LAT_SECOND + 2 : LAT_MISS;
    check(busy == exp_busy, (kind == 2'b10) ? "R5" : req, "busy cycles", busy, exp_busy);
  endtask

  // monitor: pops and compares each response
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          int   lat;
          int   exp_lat;
          e = exp_q.pop_front();
          lat = cyc - e.acc - 1;
          exp_lat = (e.kind == 2'b01) ? LAT_FIRST : (e.kind == 2'b10) ? LAT_SECOND : LAT_MISS;
          check(rsp_kind == e.kind, e.req, "rsp_kind", rsp_kind, e.kind);
          check(rsp_data == line_of(e.addr), e.req, "rsp_data", rsp_data, line_of(e.addr));
          check(lat == exp_lat, e.req, "latency", lat, exp_lat);
        end
      end
    end
  end

  // next-level memory model
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        logic [ADDR_W-1:0] ma;
        ma = mem_req_addr;
        check(ma == cur_addr, "R6", "mem_req_addr", ma, cur_addr);
        @(negedge clk);
        check(!mem_req_valid, "R6", "mem_req_valid pulse width", mem_req_valid, 0);
        repeat (MEM_LAT - 1) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = line_of(ma);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  localparam logic [ADDR_W-1:0] A_ADDR = 12'h012; // idx 2
  localparam logic [ADDR_W-1:0] B_ADDR = 12'h01A; // idx 10 = partner of 2, same upper bits
  localparam logic [ADDR_W-1:0] C_ADDR = 12'h022; // idx 2, other upper bits
  localparam logic [ADDR_W-1:0] D_ADDR = 12'h305; // unrelated pair

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    cur_addr  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", mem_req_valid, 0);

    issue(A_ADDR, 2'b11, "R1");      // empty store: refill
    issue(A_ADDR, 2'b01, "R2");      // direct hit
    issue(B_ADDR, 2'b11, "R8");      // differs only in idx MSB: no false hit
    issue(A_ADDR, 2'b01, "R8");
    issue(B_ADDR, 2'b01, "R2");
    issue(D_ADDR, 2'b11, "R6");
    issue(D_ADDR, 2'b01, "R2");
    issue(C_ADDR, 2'b11, "R7");      // C home at 2, A moved to 10, B dropped
    issue(C_ADDR, 2'b01, "R7");
    issue(A_ADDR, 2'b10, "R3");      // A found at partner, exchange
    issue(A_ADDR, 2'b01, "R4");      // now direct
    issue(C_ADDR, 2'b10, "R4");      // C moved to partner
    issue(C_ADDR, 2'b01, "R4");
    issue(B_ADDR, 2'b11, "R7");      // dropped earlier; B home 10, A moves to 2, C dropped
    issue(A_ADDR, 2'b01, "R7");
    issue(B_ADDR, 2'b01, "R7");
    issue(C_ADDR, 2'b11, "R7");

    // stray next-level response while idle
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 16'hFFFF;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    for (int i = 0; i < 3; i++) begin
      check(rsp_valid == 1'b0, "R9", "rsp_valid after idle mem_rsp_valid", rsp_valid, 0);
      check(req_ready == 1'b1, "R9", "req_ready after idle mem_rsp_valid", req_ready, 1);
      @(negedge clk);
    end
    issue(C_ADDR, 2'b01, "R9");      // store untouched

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2", "responses outstanding", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule